// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block starts and halts a parameterised group of virtual processors and keeps a bitmap of which of them are running. Software reaches three 64-bit registers: a start register, a halt register and a read-only status register. Writing a bit mask to the start register launches a reset for each idle processor named in the mask. Writing a mask to the halt register stops each running processor named in it.

Starting is a two-step exchange. The controller pulses a per-processor reset request, and the processor later answers with a reset acknowledge. The status bit goes high only when that acknowledge arrives. Halting is immediate: the controller pulses a per-processor halt request and clears the status bit in the same edge. The registers appear at two alias windows, a local window and a remote window, which behave the same.

After reset the bitmap is empty, and the controller automatically launches the processors named in a boot mask parameter.

Top module: `vpRunCtl`

## Requirements
- R1: Only the low NUM_VP bits of a start or halt write act; higher data bits have no effect on any processor.
- R2: A write to the start register (offset 0x00) pulses `vpResetReq` for one cycle, in the cycle after the write edge. The pulse goes only to processors named in the data that are neither running nor already waiting for an acknowledge. A repeat start while a processor waits produces no second pulse.
- R3: A processor's status bit is set by the first clock edge at which its `vpResetAck` is high while its start is pending. It is not set by the start write itself.
- R4: A write to the halt register (offset 0x08) pulses `vpHaltReq` for one cycle in the cycle after the write edge. The pulse goes only to named processors that are running. Their status bits are clear from that same cycle on.
- R5: A read of the status register (offset 0x10) returns the running bitmap zero-extended to 64 bits on `rdData`, combinationally in the cycle `rdEn` is high. Bit i belongs to processor i.
- R6: The three registers decode at LOCAL_BASE plus offset and at REMOTE_BASE plus offset (defaults 0x000 and 0x100), with identical behaviour.
- R7: A read at any other address returns zero, and a write at any other address changes no processor state.
- R8: Reset clears the bitmap and all requests. In the first clock edge after reset is released, the controller issues a start for each processor set in VP_START_RUNNING (default 1, with NUM_VP default 1).
- R9: A VP_START_RUNNING with a bit at or above NUM_VP, or a NUM_VP outside 1 to 64, stops elaboration with an error.
- R10: An acknowledge for a processor with no pending start is ignored.
- R11: A halt write naming a processor cancels its pending start, so a later acknowledge does not set its status bit. A halt in the same edge as the boot start suppresses that processor's boot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address within the window |
| wrData | input | DATA_W | Write data (processor mask) |
| rdData | output | DATA_W | Read data, combinational |
| vpResetReq | output | NUM_VP | One-cycle reset/start pulse per processor |
| vpHaltReq | output | NUM_VP | One-cycle halt pulse per processor |
| vpResetAck | input | NUM_VP | Reset-completed acknowledge per processor |

## Verification
A stub answers each reset pulse after a per-processor delay. A start with all high bits set and the valid bits clear separates correct masking from sign or width errors. A start that names both running and idle processors checks the idle-only filter, and a repeated start during the wait checks that no second pulse is issued. Repeated halts, halts through the remote alias, stray acknowledges, writes to unmapped addresses, a halt during a pending start and a halt in the boot edge each change exactly one rule. A cycle-by-cycle model of the request pulses runs alongside these checks.

// File: rtl/vpRunCtl_pkg.sv
package vpRunCtl_pkg;

  // Register offsets inside one alias window
  localparam int unsigned OFS_START  = 'h00;
  localparam int unsigned OFS_HALT   = 'h08;
  localparam int unsigned OFS_STATUS = 'h10;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic startWr;
    logic haltWr;
    logic statusRd;
    logic bootStart;
  } ctlStrobes_t;

endpackage

// File: rtl/vpRunCtl_ctrl.sv
module vpRunCtl_ctrl
  import vpRunCtl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned LOCAL_BASE  = 'h000,
  parameter int unsigned REMOTE_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes
);

  localparam int NUM_ALIAS = 2;

  logic [NUM_ALIAS-1:0] hitStart;
  logic [NUM_ALIAS-1:0] hitHalt;
  logic [NUM_ALIAS-1:0] hitStatus;
  logic                 bootFlag;

  // One decoder per alias window (R6)
  for (genvar b = 0; b < NUM_ALIAS; b++) begin : g_alias
    localparam int unsigned BASE = (b == 0) ? LOCAL_BASE : REMOTE_BASE;
    assign hitStart[b]  = (addr == ADDR_W'(BASE + OFS_START));
    assign hitHalt[b]   = (addr == ADDR_W'(BASE + OFS_HALT));
    assign hitStatus[b] = (addr == ADDR_W'(BASE + OFS_STATUS));
  end

  // Boot start is issued in the first edge after reset release (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootFlag <= 1'b1;
    else       bootFlag <= 1'b0;
  end

  always_comb begin
    strobes.startWr   = wrEn & (|hitStart);
    strobes.haltWr    = wrEn & (|hitHalt);
    strobes.statusRd  = rdEn & (|hitStatus);
    strobes.bootStart = bootFlag;
  end

endmodule

// File: rtl/vpRunCtl_dp.sv
module vpRunCtl_dp
  import vpRunCtl_pkg::*;
#(
  parameter int unsigned NUM_VP     = 1,
  parameter int unsigned DATA_W     = 64,
  parameter logic [63:0] START_MASK = 64'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_VP-1:0] vpResetAck,
  output logic [NUM_VP-1:0] vpResetReq,
  output logic [NUM_VP-1:0] vpHaltReq,
  output logic [NUM_VP-1:0] running,
  output logic [NUM_VP-1:0] pending,
  output logic [DATA_W-1:0] rdData
);

  // Data bits above NUM_VP are discarded (R1)
  if (NUM_VP < DATA_W) begin : g_hi
    logic unusedHiBits;
    assign unusedHiBits = ^wrData[DATA_W-1:NUM_VP];
  end

  // One slice per processor
  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    logic reqStart;
    logic reqHalt;
    logic launch;

    assign reqStart = (strobes.startWr & wrData[i]) | (strobes.bootStart & START_MASK[i]);
    assign reqHalt  = strobes.haltWr & wrData[i];
    // A halt in the same edge wins over a start (R11)
    assign launch   = reqStart & ~running[i] & ~pending[i] & ~reqHalt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        running[i]    <= 1'b0;
        pending[i]    <= 1'b0;
        vpResetReq[i] <= 1'b0;
        vpHaltReq[i]  <= 1'b0;
      end else begin
        vpResetReq[i] <= launch;
        vpHaltReq[i]  <= reqHalt & running[i];
        if (reqHalt) begin
          running[i] <= 1'b0;
          pending[i] <= 1'b0;
        end else if (pending[i] && vpResetAck[i]) begin
          running[i] <= 1'b1;
          pending[i] <= 1'b0;
        end else if (launch) begin
          pending[i] <= 1'b1;
        end
      end
    end
  end

  // Combinational status read, zero elsewhere (R5, R7)
  assign rdData = strobes.statusRd ? DATA_W'(running) : '0;

endmodule

// File: rtl/vpRunCtl.sv
module vpRunCtl
  import vpRunCtl_pkg::*;
#(
  parameter int unsigned NUM_VP           = 1,
  parameter logic [63:0] VP_START_RUNNING = 64'h1,
  parameter int unsigned ADDR_W           = 12,
  parameter int unsigned DATA_W           = 64,
  parameter int unsigned LOCAL_BASE       = 'h000,
  parameter int unsigned REMOTE_BASE      = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_VP-1:0] vpResetReq,
  output logic [NUM_VP-1:0] vpHaltReq,
  input  logic [NUM_VP-1:0] vpResetAck
);

  localparam logic [63:0] VALID_MASK = (NUM_VP >= 64) ? '1 : ((64'd1 << NUM_VP) - 64'd1);

  // Configuration checks at elaboration (R9)
  if (NUM_VP < 1 || NUM_VP > 64 || NUM_VP > DATA_W) begin : g_bad_count_r9
    $error("vpRunCtl: NUM_VP out of range");
  end
  if ((VP_START_RUNNING & ~VALID_MASK) != 64'd0) begin : g_bad_boot_r9
    $error("vpRunCtl: VP_START_RUNNING names a processor above NUM_VP");
  end

  ctlStrobes_t       strobes;
  logic [NUM_VP-1:0] running;
  logic [NUM_VP-1:0] pending;

  vpRunCtl_ctrl #(
    .ADDR_W     (ADDR_W),
    .LOCAL_BASE (LOCAL_BASE),
    .REMOTE_BASE(REMOTE_BASE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobes(strobes)
  );

  vpRunCtl_dp #(
    .NUM_VP    (NUM_VP),
    .DATA_W    (DATA_W),
    .START_MASK(VP_START_RUNNING)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .vpResetAck(vpResetAck),
    .vpResetReq(vpResetReq),
    .vpHaltReq (vpHaltReq),
    .running   (running),
    .pending   (pending),
    .rdData    (rdData)
  );

endmodule

// File: rtl/vpRunCtl_chk.sv
module vpRunCtl_chk
  import vpRunCtl_pkg::*;
#(
  parameter int unsigned NUM_VP      = 1,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned LOCAL_BASE  = 'h000,
  parameter int unsigned REMOTE_BASE = 'h100
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic [NUM_VP-1:0] vpResetReq,
  input logic [NUM_VP-1:0] vpHaltReq,
  input logic [NUM_VP-1:0] vpResetAck,
  input logic [NUM_VP-1:0] running,
  input logic [NUM_VP-1:0] pending
);

  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (addr == ADDR_W'(LOCAL_BASE + 8 * k) || addr == ADDR_W'(REMOTE_BASE + 8 * k))
        mapped = 1'b1;
    end
  end

  p_unmapped_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |-> (rdData == '0));

  p_reset_only_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((vpResetReq & running) == '0));

  p_reset_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((vpResetReq & $past(vpResetReq)) == '0));

  p_run_needs_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((running & ~$past(running) & ~$past(vpResetAck)) == '0));

  p_stray_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((running & ~$past(running) & ~$past(pending)) == '0));

  p_halt_only_running_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|vpHaltReq) |-> ((vpHaltReq & ~$past(running)) == '0));

  p_halt_clears_running_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((vpHaltReq & running) == '0));

endmodule

bind vpRunCtl vpRunCtl_chk #(
  .NUM_VP     (NUM_VP),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LOCAL_BASE (LOCAL_BASE),
  .REMOTE_BASE(REMOTE_BASE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .vpResetReq(vpResetReq),
  .vpHaltReq (vpHaltReq),
  .vpResetAck(vpResetAck),
  .running   (running),
  .pending   (pending)
);

// File: tb/vpRunCtl_test.sv
module vpRunCtl_test;

  localparam int          NV    = 4;
  localparam logic [63:0] BOOT  = 64'h5;
  localparam logic [11:0] L_RUN = 12'h000, L_HLT = 12'h008, L_STS = 12'h010;
  localparam logic [11:0] R_RUN = 12'h100, R_HLT = 12'h108, R_STS = 12'h110;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [63:0]   wrData = '0;
  logic [63:0]   rdData;
  logic [NV-1:0] vpResetReq;
  logic [NV-1:0] vpHaltReq;
  logic [NV-1:0] stubAck = '0;
  logic [NV-1:0] forceAck = '0;
  logic [NV-1:0] ackBus;
  logic          stubOn = 1'b1;

  int checks = 0;
  int errs = 0;

  assign ackBus = stubAck | forceAck;

  always #4 clk = ~clk;

  vpRunCtl #(.NUM_VP(NV), .VP_START_RUNNING(BOOT)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .vpResetReq(vpResetReq),
    .vpHaltReq(vpHaltReq), .vpResetAck(ackBus)
  );

  // Behavioural reference for the pulse outputs
  logic [NV-1:0] mRun, mPend, eRst, eHalt;
  bit mBoot;
  always @(posedge clk) begin
    if (!rstN) begin
      mRun = '0; mPend = '0; eRst = '0; eHalt = '0; mBoot = 1;
    end else begin
      for (int i = 0; i < NV; i++) begin
        bit wantGo, wantHalt;
        wantGo   = (wrEn && (addr == L_RUN || addr == R_RUN) && wrData[i]) || (mBoot && BOOT[i]);
        wantHalt = wrEn && (addr == L_HLT || addr == R_HLT) && wrData[i];
        eRst[i] = 0; eHalt[i] = 0;
        if (wantHalt) begin
          eHalt[i] = mRun[i]; mRun[i] = 0; mPend[i] = 0;
        end else if (mPend[i] && ackBus[i]) begin
          mRun[i] = 1; mPend[i] = 0;
        end else if (wantGo && !mRun[i] && !mPend[i]) begin
          mPend[i] = 1; eRst[i] = 1;
        end
      end
      mBoot = 0;
    end
  end

  // Per-cycle comparison, then the acknowledge stub (VP i answers after i+1 cycles)
  int cnt [NV];
  always @(negedge clk) begin
    checks++;
    if (vpResetReq !== eRst) begin
      errs++;
      $display("FAIL R2/R8/R11 vpResetReq actual=%b expected=%b at %0t", vpResetReq, eRst, $time);
    end
    checks++;
    if (vpHaltReq !== eHalt) begin
      errs++;
      $display("FAIL R4 vpHaltReq actual=%b expected=%b at %0t", vpHaltReq, eHalt, $time);
    end
    for (int i = 0; i < NV; i++) begin
      stubAck[i] <= 1'b0;
      if (!rstN) cnt[i] = 0;
      else begin
        if (cnt[i] > 0) begin
          cnt[i] = cnt[i] - 1;
          if (cnt[i] == 0) stubAck[i] <= 1'b1;
        end
        if (stubOn && vpResetReq[i]) cnt[i] = i + 1;
      end
    end
  end

  task automatic doWrite(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); #1;
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 0; wrData = '0; addr = '0;
  endtask

  task automatic readChk(input logic [11:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); #1;
    rdEn = 1; addr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      errs++;
      $display("FAIL %s read 0x%h actual=0x%h expected=0x%h", tag, a, rdData, exp);
    end
    rdEn = 0; addr = '0;
  endtask

  task automatic pulseAck(input logic [NV-1:0] m);
    @(negedge clk); #1;
    forceAck = m;
    @(negedge clk); #1;
    forceAck = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle(3);
    readChk(L_STS, 64'h0, "R8 status in reset");
    @(negedge clk); #1 rstN = 1;
    idle(8);
    readChk(L_STS, 64'h5, "R8/R3 boot start acknowledged");

    doWrite(R_RUN, 64'hFFFF_FFFF_FFFF_FFF0);
    idle(4);
    readChk(L_STS, 64'h5, "R1 high data bits ignored");

    doWrite(R_RUN, 64'hF);
    readChk(L_STS, 64'h5, "R3 status not set at write");
    doWrite(L_RUN, 64'hF);
    idle(8);
    readChk(L_STS, 64'hF, "R2/R3 idle processors started");

    doWrite(L_HLT, 64'h3);
    readChk(L_STS, 64'hC, "R4 halted bits cleared");
    doWrite(L_HLT, 64'h3);
    idle(2);
    readChk(L_STS, 64'hC, "R4 halt of stopped processor");
    doWrite(R_HLT, 64'h4);
    readChk(R_STS, 64'h8, "R6 remote halt and remote status");
    readChk(L_STS, 64'h8, "R6 local status alias");
    readChk(R_STS, 64'h8, "R5 status read");

    pulseAck(4'h1);
    idle(2);
    readChk(L_STS, 64'h8, "R10 stray acknowledge");

    doWrite(12'h018, 64'hF);
    doWrite(12'h0F8, 64'hF);
    doWrite(12'h118, 64'hF);
    idle(6);
    readChk(12'h018, 64'h0, "R7 unmapped read");
    readChk(12'h118, 64'h0, "R7 unmapped read remote");
    readChk(L_STS, 64'h8, "R7 unmapped write no effect");

    stubOn = 0;
    doWrite(L_RUN, 64'h1);
    doWrite(L_HLT, 64'h1);
    pulseAck(4'h1);
    idle(2);
    readChk(L_STS, 64'h8, "R11 halt cancels pending start");
    stubOn = 1;
    doWrite(L_RUN, 64'h1);
    idle(4);
    readChk(L_STS, 64'h9, "R2 restart after cancel");

    // Halt write in the boot edge
    @(negedge clk); #1 rstN = 0;
    idle(2);
    @(negedge clk); #1;
    wrEn = 1; addr = L_HLT; wrData = 64'h1; rstN = 1;
    @(negedge clk); #1;
    wrEn = 0; addr = '0; wrData = '0;
    idle(8);
    readChk(L_STS, 64'h4, "R11/R8 halt in boot edge suppresses boot start");

    idle(2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule